// File: doc/BRIEF.md
# Multi-Type Peripheral Reset Controller

This block drives a bank of reset lines for the peripherals and cores of a chip. Each line is tied at build time to one of five behaviour kinds. The kinds differ in four ways: whether hardware drops the request by itself, whether a write needs a guard bit, whether completion is recorded in a done flag, and the polarity of the output. Software starts or ends a reset by writing the channel's control word. The channel then runs a short sequence. It stops the peripheral clock first. It then moves the reset line, waits a programmable number of 0.25 µs ticks with the clock still stopped, and starts the clock again.

Each channel has a control word and a hold word. The channel index sits in the upper address bits, and address bit 0 selects between the two words (0 = control, 1 = hold). In the control word, bit 0 is the request and bit 1 is the done flag. Writing 1 to bit 1 clears the done flag. Bit 16 is the write guard for the kinds that have one. The tick input is a one-cycle enable that pulses every 0.25 µs. A per-channel flush-acknowledge input ends a cache-flush reset. The clock-enable outputs go to external gating cells.

Top module: `rstc_top`

## Requirements
- R1: After reset, every request, done flag and hold word reads 0. Every clock enable is 1 and every reset output is inactive: 0 for active-high lines and 1 for active-low lines.
- R2: The hold word keeps 8 bits for auto-pulse channels (kind 3) and 4 bits for every other kind. Higher written bits are dropped, and the hold word reads back zero-extended.
- R3: For core-pulse (kind 0), core-level (kind 1) and cache-flush (kind 2) channels, a control write changes the request only when bit 16 of that write is 1.
- R4: For auto-pulse (kind 3) and software-level (kind 4) channels, every control write loads bit 0 into the request.
- R5: When the request differs from the applied reset, the clock enable drops on the next cycle. The reset output changes one cycle after that, and the clock enable stays low until the hold ends.
- R6: The hold phase ends on the (N+1)-th tick seen in that phase, where N is the hold word. A hold of 0 ends on the first tick.
- R7: For kinds 0 and 3, completing the assert phase clears the request by hardware. A release sequence follows, and the clock enable stays low from the start of the assert to the end of the release.
- R8: Kind 1 and kind 4 channels keep their reset applied until software writes the request back to 0.
- R9: A kind 2 channel keeps its reset applied after the hold. Its request is cleared only by a flush-acknowledge pulse that arrives while the channel is idle with the reset applied, and a release sequence then follows.
- R10: The done flag exists only for kinds 0, 1 and 3. It is set when a sequence ends and no further phase follows, and a control write with bit 1 = 1 clears it. For kinds 2 and 4 it always reads 0.
- R11: Kind 4 outputs are active low, except the channel named by HI_CH, which is active high. All other kinds are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable every 0.25 µs |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | {channel, word select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| flush_ack | input | NCH | Per-channel flush-complete pulse |
| rst_out | output | NCH | Reset lines, per-channel polarity |
| clk_en | output | NCH | Clock enables to external gating cells |

## Verification
The assertions assume that tick and flush_ack are single-cycle pulses driven on the system clock, and that bus writes are single-cycle strobes whose address selects a channel that exists. The request-stability checks also assume that no guarded-kind write sets bit 16 unless it intends to change the request. The bench drives every input at the falling edge. It raises flush_ack only after the flush channel has finished its hold and sits idle, and it sends ticks only as isolated one-cycle pulses.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [2:0] {
        KIND_CORE_PULSE  = 3'd0,
        KIND_CORE_LEVEL  = 3'd1,
        KIND_CACHE_FLUSH = 3'd2,
        KIND_AUTO_PULSE  = 3'd3,
        KIND_SW_LEVEL    = 3'd4
    } rst_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_GATE = 2'd1,
        SQ_HOLD = 2'd2
    } seq_state_e;

    localparam int BUS_W        = 32;
    localparam int HOLD_W_MAX   = 8;
    localparam int CTRL_REQ_BIT = 0;
    localparam int CTRL_DONE_BIT = 1;
    localparam int CTRL_WE_BIT  = 16;

    typedef struct packed {
        logic              ctrl;
        logic              hold;
        logic [BUS_W-1:0]  data;
    } chan_wr_t;

    function automatic bit kind_has_we(rst_kind_e k);
        return (k == KIND_CORE_PULSE) || (k == KIND_CORE_LEVEL) || (k == KIND_CACHE_FLUSH);
    endfunction

    function automatic bit kind_has_done(rst_kind_e k);
        return (k == KIND_CORE_PULSE) || (k == KIND_CORE_LEVEL) || (k == KIND_AUTO_PULSE);
    endfunction

    function automatic bit kind_auto_clr(rst_kind_e k);
        return (k == KIND_CORE_PULSE) || (k == KIND_AUTO_PULSE);
    endfunction

    function automatic int kind_hold_w(rst_kind_e k);
        return (k == KIND_AUTO_PULSE) ? 8 : 4;
    endfunction

    function automatic bit kind_act_low(rst_kind_e k, int ch, int hi_ch);
        return (k == KIND_SW_LEVEL) && (ch != hi_ch);
    endfunction

endpackage

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_W   = 4,
    parameter bit AUTO_CLR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic [HOLD_W-1:0] hold,
    output logic              applied,
    output logic              clk_en,
    output logic              idle,
    output logic              cmp,
    output logic              cmp_tgt
);

    seq_state_e        state_q;
    logic              tgt_q;
    logic              applied_q;
    logic [HOLD_W-1:0] cnt_q;
    logic              hold_end;

    assign hold_end = (state_q == SQ_HOLD) && tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            tgt_q     <= 1'b0;
            applied_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (req != applied_q) begin
                        tgt_q   <= req;
                        state_q <= SQ_GATE;
                    end
                end
                SQ_GATE: begin
                    applied_q <= tgt_q;
                    cnt_q     <= hold;
                    state_q   <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            if (AUTO_CLR && tgt_q) begin
                                tgt_q   <= 1'b0;
                                state_q <= SQ_GATE;
                            end else begin
                                state_q <= SQ_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign applied = applied_q;
    assign clk_en  = (state_q == SQ_IDLE);
    assign idle    = (state_q == SQ_IDLE);
    assign cmp     = hold_end;
    assign cmp_tgt = tgt_q;

    // R5: the reset line only moves on the edge that leaves the gate phase
    p_apply_in_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(applied_q) |-> ($past(state_q) == SQ_GATE) && !clk_en);

    // R6: the hold phase is left only on a tick
    p_hold_waits_tick_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_HOLD && !tick) |=> (state_q == SQ_HOLD));

endmodule

// File: rtl/rstc_chan_regs.sv
module rstc_chan_regs
    import rstc_pkg::*;
#(
    parameter rst_kind_e KIND   = KIND_CORE_LEVEL,
    parameter int        HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic              flush_ack,
    input  logic              seq_idle,
    input  logic              applied,
    input  logic              cmp,
    input  logic              cmp_tgt,
    output logic              req,
    output logic              done,
    output logic [HOLD_W-1:0] hold
);

    localparam bit HAS_WE   = kind_has_we(KIND);
    localparam bit HAS_DONE = kind_has_done(KIND);
    localparam bit AUTO     = kind_auto_clr(KIND);
    localparam bit IS_FLUSH = (KIND == KIND_CACHE_FLUSH);

    logic              req_q;
    logic              done_q;
    logic [HOLD_W-1:0] hold_q;
    logic              hw_clr;
    logic              sw_req_wr;
    logic              done_set;
    logic              unused_bits;

    assign unused_bits = ^wr.data;

    assign hw_clr = (AUTO && cmp && cmp_tgt) ||
                    (IS_FLUSH && flush_ack && seq_idle && applied && req_q);
    assign sw_req_wr = wr.ctrl && (!HAS_WE || wr.data[CTRL_WE_BIT]);
    assign done_set  = HAS_DONE && cmp && !(AUTO && cmp_tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (hw_clr) begin
                req_q <= 1'b0;
            end else if (sw_req_wr) begin
                req_q <= wr.data[CTRL_REQ_BIT];
            end
            if (done_set) begin
                done_q <= 1'b1;
            end else if (wr.ctrl && wr.data[CTRL_DONE_BIT]) begin
                done_q <= 1'b0;
            end
            if (wr.hold) begin
                hold_q <= wr.data[HOLD_W-1:0];
            end
        end
    end

    assign req  = req_q;
    assign done = done_q;
    assign hold = hold_q;

    // R10: the done flag only rises on a sequence completion
    p_done_from_cmp_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(cmp));

    if (HAS_WE) begin : g_we_chk
        // R3: an unguarded write leaves the request alone
        p_we_guard_r3: assert property (@(posedge clk) disable iff (rst)
            (wr.ctrl && !wr.data[CTRL_WE_BIT] && !hw_clr) |=> $stable(req_q));
    end

    if (IS_FLUSH) begin : g_flush_chk
        // R9: without an acknowledge the flush request persists
        p_flush_wait_r9: assert property (@(posedge clk) disable iff (rst)
            (req_q && applied && seq_idle && !flush_ack && !wr.ctrl) |=> req_q);
    end

endmodule

// File: rtl/rstc_rdmux.sv
module rstc_rdmux
    import rstc_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NCH-1:0]        req,
    input  logic [NCH-1:0]        done,
    input  logic [HOLD_W_MAX-1:0] hold [NCH],
    output logic [BUS_W-1:0]      rdata
);

    logic [ADDR_W-2:0] idx;

    assign idx = addr[ADDR_W-1:1];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(idx) == i) begin
                if (addr[0]) begin
                    rdata[HOLD_W_MAX-1:0] = hold[i];
                end else begin
                    rdata[CTRL_REQ_BIT]  = req[i];
                    rdata[CTRL_DONE_BIT] = done[i];
                end
            end
        end
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int              NCH    = 6,
    parameter logic [3*NCH-1:0] KINDS = {3'd4, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    parameter int              HI_CH  = 5,
    parameter int              ADDR_W = $clog2(NCH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NCH-1:0]    flush_ack,
    output logic [NCH-1:0]    rst_out,
    output logic [NCH-1:0]    clk_en
);

    logic [NCH-1:0]        req_v;
    logic [NCH-1:0]        done_v;
    logic [HOLD_W_MAX-1:0] hold_a [NCH];
    logic [ADDR_W-2:0]     sel_ch;

    assign sel_ch = bus_addr[ADDR_W-1:1];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam rst_kind_e K  = rst_kind_e'(KINDS[3*i +: 3]);
        localparam int        HW = kind_hold_w(K);
        localparam bit        AL = kind_act_low(K, i, HI_CH);

        chan_wr_t     wr_l;
        logic [HW-1:0] hold_l;
        logic          applied_l;
        logic          idle_l;
        logic          cmp_l;
        logic          tgt_l;
        logic          cen_l;

        assign wr_l.ctrl = bus_wr && (int'(sel_ch) == i) && !bus_addr[0];
        assign wr_l.hold = bus_wr && (int'(sel_ch) == i) &&  bus_addr[0];
        assign wr_l.data = bus_wdata;

        rstc_chan_regs #(.KIND(K), .HOLD_W(HW)) i_regs (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_l),
            .flush_ack (flush_ack[i]),
            .seq_idle  (idle_l),
            .applied   (applied_l),
            .cmp       (cmp_l),
            .cmp_tgt   (tgt_l),
            .req       (req_v[i]),
            .done      (done_v[i]),
            .hold      (hold_l)
        );

        rstc_seq #(.HOLD_W(HW), .AUTO_CLR(kind_auto_clr(K))) i_seq (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .req     (req_v[i]),
            .hold    (hold_l),
            .applied (applied_l),
            .clk_en  (cen_l),
            .idle    (idle_l),
            .cmp     (cmp_l),
            .cmp_tgt (tgt_l)
        );

        assign hold_a[i]  = HOLD_W_MAX'(hold_l);
        assign rst_out[i] = AL ? ~applied_l : applied_l;
        assign clk_en[i]  = cen_l;

        // R11: output level follows the applied state with the built polarity
        p_polarity_r11: assert property (@(posedge clk) disable iff (rst)
            !$stable(applied_l) |-> (rst_out[i] == (applied_l ^ AL)));
    end

    rstc_rdmux #(.NCH(NCH), .ADDR_W(ADDR_W)) i_rd (
        .addr  (bus_addr),
        .req   (req_v),
        .done  (done_v),
        .hold  (hold_a),
        .rdata (bus_rdata)
    );

endmodule

// File: tb/test_rstc_top.sv
`timescale 1ns/1ps
module test_rstc_top;

    localparam int NCH = 6;
    localparam int AW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  flush_ack = '0;
    logic [NCH-1:0]  rst_out;
    logic [NCH-1:0]  clk_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rstc_top i_rstc_top (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flush_ack(flush_ack),
        .rst_out(rst_out), .clk_en(clk_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit hold_word, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(ch * 2 + int'(hold_word)); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input bit hold_word, output logic [31:0] d);
        bus_addr = AW'(ch * 2 + int'(hold_word));
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pulse_ack(input int ch);
        @(negedge clk); flush_ack[ch] = 1'b1;
        @(negedge clk); flush_ack[ch] = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            rd(c, 1'b0, d); chk(d == 0, "R1 ctrl", d, 0);
            rd(c, 1'b1, d); chk(d == 0, "R1 hold", d, 0);
        end
        chk(clk_en == 6'h3F, "R1 clk_en", 32'(clk_en), 32'h3F);
        chk(rst_out == 6'h10, "R1 rst_out", 32'(rst_out), 32'h10);
    endtask

    task automatic t_hold_width;
        logic [31:0] d;
        wr(1, 1'b1, 32'hFF); rd(1, 1'b1, d); chk(d == 32'h0F, "R2 4-bit hold", d, 32'h0F);
        wr(3, 1'b1, 32'h1FF); rd(3, 1'b1, d); chk(d == 32'hFF, "R2 8-bit hold", d, 32'hFF);
    endtask

    task automatic t_core_level;
        logic [31:0] d;
        wr(1, 1'b1, 32'd3);
        wr(1, 1'b0, 32'h1);
        @(negedge clk); @(negedge clk);
        rd(1, 1'b0, d); chk(d == 0, "R3 unguarded write ignored", d, 0);
        chk(clk_en[1] == 1'b1, "R3 no sequence", 32'(clk_en[1]), 1);
        wr(1, 1'b0, 32'h10001);
        chk(clk_en[1] == 1'b1 && rst_out[1] == 1'b0, "R5 before start", 32'({clk_en[1], rst_out[1]}), 32'h2);
        @(negedge clk);
        chk(clk_en[1] == 1'b0 && rst_out[1] == 1'b0, "R5 clock stops first", 32'({clk_en[1], rst_out[1]}), 0);
        @(negedge clk);
        chk(rst_out[1] == 1'b1 && clk_en[1] == 1'b0, "R5 reset applied", 32'({clk_en[1], rst_out[1]}), 1);
        pulse_tick(3);
        chk(clk_en[1] == 1'b0, "R6 still holding after N ticks", 32'(clk_en[1]), 0);
        pulse_tick(1);
        chk(clk_en[1] == 1'b1, "R6 hold ends on tick N+1", 32'(clk_en[1]), 1);
        repeat (3) @(negedge clk);
        chk(rst_out[1] == 1'b1, "R8 reset stays applied", 32'(rst_out[1]), 1);
        rd(1, 1'b0, d); chk(d == 32'h3, "R10 done after assert", d, 32'h3);
        wr(1, 1'b0, 32'h2);
        rd(1, 1'b0, d); chk(d == 32'h1, "R10 done cleared by write of 1", d, 32'h1);
        wr(1, 1'b0, 32'h10000);
        @(negedge clk); @(negedge clk);
        chk(rst_out[1] == 1'b0 && clk_en[1] == 1'b0, "R8 release applied", 32'({clk_en[1], rst_out[1]}), 0);
        pulse_tick(4);
        chk(clk_en[1] == 1'b1, "R5 clock restored after release", 32'(clk_en[1]), 1);
        rd(1, 1'b0, d); chk(d == 32'h2, "R10 done after release", d, 32'h2);
        wr(1, 1'b0, 32'h2);
    endtask

    task automatic t_core_pulse;
        logic [31:0] d;
        wr(0, 1'b1, 32'd2);
        wr(0, 1'b0, 32'h10001);
        @(negedge clk); @(negedge clk);
        chk(rst_out[0] == 1'b1, "R5 core pulse applied", 32'(rst_out[0]), 1);
        pulse_tick(3);
        rd(0, 1'b0, d); chk(d == 0, "R7 request cleared by hardware", d, 0);
        chk(clk_en[0] == 1'b0, "R7 clock stays low", 32'(clk_en[0]), 0);
        @(negedge clk);
        chk(rst_out[0] == 1'b0 && clk_en[0] == 1'b0, "R7 release with clock low", 32'({clk_en[0], rst_out[0]}), 0);
        pulse_tick(2);
        chk(clk_en[0] == 1'b0, "R6 release hold", 32'(clk_en[0]), 0);
        pulse_tick(1);
        chk(clk_en[0] == 1'b1, "R7 clock back after release", 32'(clk_en[0]), 1);
        rd(0, 1'b0, d); chk(d == 32'h2, "R10 done after pulse", d, 32'h2);
    endtask

    task automatic t_auto_pulse;
        logic [31:0] d;
        wr(3, 1'b1, 32'd0);
        wr(3, 1'b0, 32'h1);
        @(negedge clk); @(negedge clk);
        chk(rst_out[3] == 1'b1, "R4 direct write starts reset", 32'(rst_out[3]), 1);
        pulse_tick(1);
        @(negedge clk);
        chk(rst_out[3] == 1'b0 && clk_en[3] == 1'b0, "R6 zero hold one tick", 32'({clk_en[3], rst_out[3]}), 0);
        pulse_tick(1);
        chk(clk_en[3] == 1'b1, "R7 auto pulse done", 32'(clk_en[3]), 1);
        rd(3, 1'b0, d); chk(d == 32'h2, "R10 auto pulse done flag", d, 32'h2);
        wr(3, 1'b1, 32'd20);
        wr(3, 1'b0, 32'h3);
        @(negedge clk); @(negedge clk);
        pulse_tick(20);
        chk(rst_out[3] == 1'b1 && clk_en[3] == 1'b0, "R2 8-bit hold beyond 15", 32'({clk_en[3], rst_out[3]}), 1);
        pulse_tick(1);
        @(negedge clk);
        pulse_tick(21);
        chk(clk_en[3] == 1'b1 && rst_out[3] == 1'b0, "R7 long pulse ends", 32'({clk_en[3], rst_out[3]}), 2);
    endtask

    task automatic t_flush;
        logic [31:0] d;
        wr(2, 1'b1, 32'd1);
        wr(2, 1'b0, 32'h10001);
        @(negedge clk); @(negedge clk);
        pulse_tick(2);
        repeat (3) @(negedge clk);
        chk(clk_en[2] == 1'b1 && rst_out[2] == 1'b1, "R9 reset held after hold", 32'({clk_en[2], rst_out[2]}), 3);
        rd(2, 1'b0, d); chk(d == 32'h1, "R10 no done for flush", d, 32'h1);
        wr(2, 1'b0, 32'h0);
        rd(2, 1'b0, d); chk(d == 32'h1, "R3 flush needs guard bit", d, 32'h1);
        pulse_ack(2);
        rd(2, 1'b0, d); chk(d == 0, "R9 ack clears request", d, 0);
        @(negedge clk);
        chk(clk_en[2] == 1'b0, "R9 release clock stop", 32'(clk_en[2]), 0);
        @(negedge clk);
        chk(rst_out[2] == 1'b0, "R9 reset released", 32'(rst_out[2]), 0);
        pulse_tick(2);
        chk(clk_en[2] == 1'b1, "R9 clock back", 32'(clk_en[2]), 1);
    endtask

    task automatic t_sw_level;
        logic [31:0] d;
        wr(4, 1'b1, 32'h25);
        rd(4, 1'b1, d); chk(d == 32'h5, "R2 sw hold 4-bit", d, 32'h5);
        wr(4, 1'b0, 32'h1);
        @(negedge clk); @(negedge clk);
        chk(rst_out[4] == 1'b0, "R11 active low applied", 32'(rst_out[4]), 0);
        pulse_tick(6);
        repeat (4) @(negedge clk);
        chk(clk_en[4] == 1'b1 && rst_out[4] == 1'b0, "R8 sw level stays", 32'({clk_en[4], rst_out[4]}), 2);
        rd(4, 1'b0, d); chk(d == 32'h1, "R10 no done for sw level", d, 32'h1);
        wr(4, 1'b0, 32'h0);
        @(negedge clk); @(negedge clk);
        chk(rst_out[4] == 1'b1, "R11 active low released", 32'(rst_out[4]), 1);
        pulse_tick(6);
        wr(5, 1'b0, 32'h1);
        @(negedge clk); @(negedge clk);
        chk(rst_out[5] == 1'b1, "R11 designated channel active high", 32'(rst_out[5]), 1);
        pulse_tick(1);
        wr(5, 1'b0, 32'h0);
        @(negedge clk); @(negedge clk);
        chk(rst_out[5] == 1'b0, "R4 sw level released", 32'(rst_out[5]), 0);
        pulse_tick(1);
        chk(clk_en == 6'h3F, "R5 all clocks running", 32'(clk_en), 32'h3F);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hold_width();
        t_core_level();
        t_core_pulse();
        t_auto_pulse();
        t_flush();
        t_sw_level();
        repeat (2) @(negedge clk);
        report();
    end

endmodule